// File: doc/BRIEF.md
# Consecutive-Ones Run Detector

The block watches a one-bit serial stream and raises a flag once it has seen three 1s in a row. A sample is taken on a rising clock edge only when its qualifier is high. Each qualified 1 moves a small saturating run counter one step up, and each qualified 0 sends the counter back to zero.

The counter is a Moore state machine with four states, held in two flip-flops with binary encoding. The states are no 1s seen (00), one 1 (01), two 1s (10), and three or more 1s (11). The detect flag is high only in the last state. It comes from a flop and never follows the input combinationally. The flag therefore stays high on every cycle of a long run of 1s and drops one cycle after the first qualified 0. A debug port shows the current two-bit state.

The run length is a parameter, default 3. The state width is derived from it.

Top module: `ones_run_detector`

## Requirements
- R1: While rst_ni is low, state_o is 00 and detect_o is 0, taking effect without waiting for a clock edge.
- R2: On a rising edge with valid_i=1 and data_i=1, the state goes from 00 to 01, from 01 to 10, and from 10 to 11.
- R3: On a rising edge with valid_i=1 and data_i=1 while the state is 11, the state stays 11.
- R4: On a rising edge with valid_i=1 and data_i=0, the state becomes 00 from any state.
- R5: On a rising edge with valid_i=0, the state does not change, whatever the value of data_i.
- R6: detect_o is 1 exactly when state_o is 11, and 0 in states 00, 01 and 10.
- R7: detect_o and state_o change only on a clock edge or on reset; a change of data_i or valid_i between edges does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies data_i for the current edge |
| data_i | input | 1 | Serial input bit |
| detect_o | output | 1 | High while three or more qualified 1s have been seen in a row |
| state_o | output | 2 | Current state: 00, 01, 10 or 11 |

## Verification
The hardest behaviour to reach is a run of 1s that is broken by cycles with valid_i low, some of which carry data_i=0. A correct design must treat such a run as unbroken. The stimulus builds runs with unqualified gaps at every count, including inside the saturated state. It also changes data_i halfway through a cycle while in state 11 to show that the output does not follow the input. A reset in the middle of a run and a long stretch of random qualified and unqualified bits complete the coverage.

// File: rtl/ord_pkg.sv
package ord_pkg;
  typedef struct packed {
    logic valid;
    logic data;
  } ord_sample_t;
endpackage

// File: rtl/ord_next_state.sv
module ord_next_state #(
  parameter int RUN_LEN = 3,
  localparam int SW = $clog2(RUN_LEN + 1)
) (
  input  ord_pkg::ord_sample_t smp_i,
  input  logic [SW-1:0]        cur_i,
  output logic [SW-1:0]        nxt_o,
  output logic                 nxt_det_o
);
  localparam logic [SW-1:0] TOP = SW'(RUN_LEN);

  always_comb begin
    if (!smp_i.valid)     nxt_o = cur_i;
    else if (!smp_i.data) nxt_o = '0;
    else if (cur_i == TOP) nxt_o = TOP;  // saturate
    else                  nxt_o = cur_i + SW'(1);
  end

  assign nxt_det_o = (nxt_o == TOP);
endmodule

// File: rtl/ord_state_reg.sv
module ord_state_reg #(
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] nxt_i,
  input  logic          nxt_det_i,
  output logic [SW-1:0] state_o,
  output logic          det_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= '0;
      det_o   <= 1'b0;
    end else begin
      state_o <= nxt_i;
      det_o   <= nxt_det_i;
    end
  end
endmodule

// File: rtl/ones_run_detector.sv
module ones_run_detector #(
  parameter int RUN_LEN = 3,
  localparam int SW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          data_i,
  output logic          detect_o,
  output logic [SW-1:0] state_o
);
  ord_pkg::ord_sample_t smp;
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  logic          det_d;
  logic          det_q;

  assign smp.valid = valid_i;
  assign smp.data  = data_i;

  ord_next_state #(.RUN_LEN(RUN_LEN)) u_next (
    .smp_i     (smp),
    .cur_i     (state_q),
    .nxt_o     (state_d),
    .nxt_det_o (det_d)
  );

  ord_state_reg #(.SW(SW)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nxt_i     (state_d),
    .nxt_det_i (det_d),
    .state_o   (state_q),
    .det_o     (det_q)
  );

  assign state_o  = state_q;
  assign detect_o = det_q;
endmodule

// File: rtl/ones_run_detector_chk.sv
module ones_run_detector_chk #(
  parameter int SW = 2,
  parameter int RUN_LEN = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          data_i,
  input logic          detect_o,
  input logic [SW-1:0] state_o
);
  localparam logic [SW-1:0] TOP = SW'(RUN_LEN);

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (state_o == '0) && !detect_o);

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && data_i && (state_o != TOP) |=> state_o == $past(state_o) + SW'(1));

  a_r3_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && data_i && (state_o == TOP) |=> state_o == TOP);

  a_r4_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !data_i |=> state_o == '0);

  a_r5_invalid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_o));

  a_r6_moore_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o == (state_o == TOP));
endmodule

bind ones_run_detector ones_run_detector_chk #(.SW(SW), .RUN_LEN(RUN_LEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .data_i   (data_i),
  .detect_o (detect_o),
  .state_o  (state_o)
);

// File: tb/ones_run_detector_tb_top.sv
module ones_run_detector_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       valid_i;
  logic       data_i;
  logic       detect_o;
  logic [1:0] state_o;

  int n_chk = 0;
  int n_fail = 0;
  int cnt = 0;  // reference run count, saturating at 3
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk_i = ~clk_i;

  ones_run_detector dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .detect_o(detect_o), .state_o(state_o)
  );

  task automatic check(input string req, input logic [1:0] st, input logic det);
    n_chk++;
    if (state_o !== st || detect_o !== det) begin
      n_fail++;
      $display("FAIL %s: state=%b detect=%b expected state=%b detect=%b",
               req, state_o, detect_o, st, det);
    end
  endtask

  // Called at a negedge: drive, check that the outputs do not move between edges, clock, compare
  task automatic step(input logic v, input logic d, input string req);
    logic [1:0] st0;
    logic       dt0;
    st0 = state_o;
    dt0 = detect_o;
    valid_i = v;
    data_i  = d;
    #1;
    check("R7", st0, dt0);
    @(posedge clk_i);
    if (v) cnt = d ? ((cnt < 3) ? cnt + 1 : 3) : 0;
    @(negedge clk_i);
    check(req, 2'(cnt), cnt == 3);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b1;
    data_i  = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1", 2'b00, 1'b0);
    rst_ni = 1'b1;

    // R2 R6: count up through every state
    step(1, 1, "R2");
    step(1, 1, "R2");
    step(1, 1, "R2 R6");
    // R3: long run stays saturated
    for (int i = 0; i < 20; i++) step(1, 1, "R3");
    // R5: invalid zeros in S3 are ignored
    step(0, 0, "R5");
    step(0, 1, "R5");
    step(1, 1, "R3");
    // R4 from S3
    step(1, 0, "R4");
    // R4 from S1 and S2
    step(1, 1, "R2");
    step(1, 0, "R4");
    step(1, 1, "R2");
    step(1, 1, "R2");
    step(1, 0, "R4");
    // R5: gaps at each count inside a run
    step(1, 1, "R2");
    step(0, 0, "R5");
    step(1, 1, "R2");
    step(0, 0, "R5");
    step(0, 1, "R5");
    step(1, 1, "R6");
    // alternating
    for (int i = 0; i < 8; i++) step(1, i[0], "R4");
    // R1 in the middle of a run, asynchronous
    step(1, 1, "R2");
    step(1, 1, "R2");
    step(1, 1, "R6");
    rst_ni = 1'b0;
    #1;
    cnt = 0;
    check("R1", 2'b00, 1'b0);
    @(negedge clk_i);
    check("R1", 2'b00, 1'b0);
    rst_ni = 1'b1;
    step(1, 1, "R2");
    // random stream
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3], "R6");
    end
    summary();
  end
endmodule